// File: doc/BRIEF.md
# Priority Interrupt Acceptor with DMA Start Dispatch

This block sits between six interrupt sources and a processor core. It keeps one pending flag per source and decides, every clock, which pending source may be accepted. A source is accepted only when the processor's current mask level is no higher than the level programmed for that source. The sources are a vertical-blank event, four timers and a serial receive event. When several sources are eligible at once, the one with the lower vector index is accepted first. The rest stay pending and are taken on later cycles.

On each acceptance the block pulses a strobe for one cycle. With it, it presents three results: the mask level the core should adopt, the address of the vector-table entry, and a start strobe for at most one of four DMA channels. The DMA strobe goes to the first channel, scanning upward from channel 0, whose start-code register holds the trigger code of the accepted source. Pushing state onto a stack and reading the vector entry are left to the core.

Top module: `irq_accept`

## Requirements
- R1: A pending source is accepted only while the current mask level `mask_i` is less than or equal to its programmed 3-bit level. Otherwise it stays pending, and it is accepted on the first cycle the condition holds.
- R2: Level fields: timer 0 uses `lvl_t01_i[2:0]`, timer 1 uses `lvl_t01_i[6:4]`, timer 2 uses `lvl_t23_i[2:0]`, timer 3 uses `lvl_t23_i[6:4]`, and serial receive uses `lvl_rx_i[2:0]`.
- R3: The vertical-blank source has a fixed level of 4, so it is accepted only while `mask_i` is 4 or lower.
- R4: On acceptance, `vec_addr_o` is 0x6FB8 plus four times the vector index. The indices are: vertical blank 5, timers 0 to 3 are 7 to 10, serial receive 12.
- R5: On acceptance, `mask_next_o` is `mask_i` plus one, or 7 when `mask_i` is already 7.
- R6: Trigger codes: vertical blank 0x0B, timers 0 to 3 are 0x10 to 0x13, serial receive 0x19. On acceptance, `dma_start_o` strobes only the lowest-numbered channel whose 8-bit field in `dma_code_i` (channel n at bits [8n+7:8n]) equals that code. It stays zero when no channel matches.
- R7: While `rx_disable_i` is 1, a serial receive request is dropped and never becomes pending. A pending serial receive is not accepted while the bit is 1.
- R8: Request bits are: bit 0 vertical blank, bits 1 to 4 timers 0 to 3, bit 5 serial receive. When several eligible sources are pending, the lowest vector index is accepted, one source per cycle.
- R9: While `rst_n` is low, all outputs are zero and every pending flag is cleared.
- R10: A request sampled at a clock edge can be accepted at that same edge. The outputs are registered, so `accept_o` is high for exactly one cycle per accepted source, and `dma_start_o` is zero whenever `accept_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 6 | One-cycle request pulses, one per source |
| lvl_t01_i | input | 8 | Level fields for timers 0 and 1 |
| lvl_t23_i | input | 8 | Level fields for timers 2 and 3 |
| lvl_rx_i | input | 8 | Level field for serial receive |
| rx_disable_i | input | 1 | Blocks the serial receive source |
| dma_code_i | input | 32 | Start codes of DMA channels 0 to 3 |
| mask_i | input | 3 | Current processor mask level |
| accept_o | output | 1 | Acceptance strobe |
| mask_next_o | output | 3 | Mask level to adopt |
| vec_addr_o | output | 24 | Vector-table entry address |
| dma_start_o | output | 4 | DMA channel start strobes |

## Verification
A new request can arrive in the same cycle that an older, previously ineligible source becomes acceptable. Several requests can also arrive together. The bench provokes both cases: it pulses all six request bits in one cycle, and it lowers the mask while a timer is held pending. The scoreboard expects one acceptance per cycle, in vector-index order. Every acceptance is compared on address, new mask level and DMA strobe. Any acceptance the scoreboard did not expect is counted as a failure.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    localparam int NSRC      = 6;
    localparam int VBL_LEVEL = 4;

    typedef enum int {
        SRC_VBL = 0,
        SRC_TM0 = 1,
        SRC_TM1 = 2,
        SRC_TM2 = 3,
        SRC_TM3 = 4,
        SRC_RX  = 5
    } src_e;

    // vector table index of each source
    function automatic int src_vector(input int s);
        case (s)
            SRC_VBL: return 5;
            SRC_TM0: return 7;
            SRC_TM1: return 8;
            SRC_TM2: return 9;
            SRC_TM3: return 10;
            default: return 12;
        endcase
    endfunction

    // DMA trigger code of each source
    function automatic int src_code(input int s);
        case (s)
            SRC_VBL: return 'h0B;
            SRC_TM0: return 'h10;
            SRC_TM1: return 'h11;
            SRC_TM2: return 'h12;
            SRC_TM3: return 'h13;
            default: return 'h19;
        endcase
    endfunction

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
    import irq_accept_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int REG_W = 8
) (
    input  logic [LVL_W-1:0] mask_i,
    input  logic [REG_W-1:0] lvl_t01_i,
    input  logic [REG_W-1:0] lvl_t23_i,
    input  logic [REG_W-1:0] lvl_rx_i,
    input  logic             rx_disable_i,
    output logic [NSRC-1:0]  ok_o
);
    localparam int HI_LSB = REG_W / 2;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        if (s == SRC_VBL) begin : g_fixed
            assign ok_o[s] = (32'(mask_i) <= VBL_LEVEL);
        end else if (s == SRC_RX) begin : g_rx
            assign ok_o[s] = !rx_disable_i && (mask_i <= lvl_rx_i[LVL_W-1:0]);
        end else begin : g_tmr
            // timers 0/1 share one register, 2/3 the other; odd timer in upper field
            localparam int LSB = (((s - 1) % 2) == 1) ? HI_LSB : 0;
            logic [REG_W-1:0] reg_sel;
            assign reg_sel  = (s <= SRC_TM1) ? lvl_t01_i : lvl_t23_i;
            assign ok_o[s]  = (mask_i <= reg_sel[LSB +: LVL_W]);
        end
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] cand_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    always_comb begin
        grant_o = '0;
        any_o   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && !any_o) begin
                grant_o[i] = 1'b1;
                any_o      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_first_match.sv
module dma_first_match #(
    parameter int NUM_DMA = 4,
    parameter int CODE_W  = 8
) (
    input  logic [CODE_W-1:0]         code_i,
    input  logic [NUM_DMA*CODE_W-1:0] chan_codes_i,
    output logic [NUM_DMA-1:0]        hit_o
);
    logic found;

    always_comb begin
        hit_o = '0;
        found = 1'b0;
        for (int c = 0; c < NUM_DMA; c++) begin
            if (!found && chan_codes_i[c*CODE_W +: CODE_W] == code_i) begin
                hit_o[c] = 1'b1;
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import irq_accept_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int VEC_BASE = 'h6FB8,
    parameter int NUM_DMA  = 4,
    parameter int CODE_W   = 8,
    parameter int LVL_W    = 3,
    parameter int REG_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           req_i,
    input  logic [REG_W-1:0]          lvl_t01_i,
    input  logic [REG_W-1:0]          lvl_t23_i,
    input  logic [REG_W-1:0]          lvl_rx_i,
    input  logic                      rx_disable_i,
    input  logic [NUM_DMA*CODE_W-1:0] dma_code_i,
    input  logic [LVL_W-1:0]          mask_i,
    output logic                      accept_o,
    output logic [LVL_W-1:0]          mask_next_o,
    output logic [ADDR_W-1:0]         vec_addr_o,
    output logic [NUM_DMA-1:0]        dma_start_o
);
    localparam logic [LVL_W-1:0] MASK_TOP = '1;

    typedef struct packed {
        logic              accept;
        logic [LVL_W-1:0]  mask;
        logic [ADDR_W-1:0] addr;
        logic [NUM_DMA-1:0] dma;
        logic [NSRC-1:0]   pend;
    } state_t;

    state_t st_d, st_q;

    logic [NSRC-1:0]    eligible, pend_all, cand, grant;
    logic               any_grant;
    logic [NSRC-1:0]    capture;
    logic [CODE_W-1:0]  sel_code;
    logic [ADDR_W-1:0]  sel_addr;
    logic [NUM_DMA-1:0] dma_hit;

    irq_level_gate #(.LVL_W(LVL_W), .REG_W(REG_W)) u_gate (
        .mask_i       (mask_i),
        .lvl_t01_i    (lvl_t01_i),
        .lvl_t23_i    (lvl_t23_i),
        .lvl_rx_i     (lvl_rx_i),
        .rx_disable_i (rx_disable_i),
        .ok_o         (eligible)
    );

    irq_pick #(.N(NSRC)) u_pick (
        .cand_i  (cand),
        .grant_o (grant),
        .any_o   (any_grant)
    );

    dma_first_match #(.NUM_DMA(NUM_DMA), .CODE_W(CODE_W)) u_dma (
        .code_i       (sel_code),
        .chan_codes_i (dma_code_i),
        .hit_o        (dma_hit)
    );

    always_comb begin
        // a disabled receive source never latches its request
        capture         = req_i;
        capture[SRC_RX] = req_i[SRC_RX] & ~rx_disable_i;
        pend_all        = st_q.pend | capture;
        cand            = pend_all & eligible;

        sel_code = '0;
        sel_addr = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (grant[s]) begin
                sel_code = CODE_W'(src_code(s));
                sel_addr = ADDR_W'(VEC_BASE + 4 * src_vector(s));
            end
        end

        st_d        = st_q;
        st_d.accept = any_grant;
        st_d.pend   = pend_all & ~grant;
        st_d.mask   = '0;
        st_d.addr   = '0;
        st_d.dma    = '0;
        if (any_grant) begin
            st_d.mask = (mask_i == MASK_TOP) ? MASK_TOP : mask_i + 1'b1;
            st_d.addr = sel_addr;
            st_d.dma  = dma_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign accept_o    = st_q.accept;
    assign mask_next_o = st_q.mask;
    assign vec_addr_o  = st_q.addr;
    assign dma_start_o = st_q.dma;

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
    parameter int ADDR_W   = 24,
    parameter int VEC_BASE = 'h6FB8,
    parameter int NUM_DMA  = 4,
    parameter int LVL_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  mask_i,
    input logic              rx_disable_i,
    input logic              accept_o,
    input logic [LVL_W-1:0]  mask_next_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic [NUM_DMA-1:0] dma_start_o
);
    localparam logic [ADDR_W-1:0] VBL_ADDR = ADDR_W'(VEC_BASE + 4 * 5);
    localparam logic [ADDR_W-1:0] RX_ADDR  = ADDR_W'(VEC_BASE + 4 * 12);
    localparam logic [LVL_W-1:0]  TOP      = '1;

    assert_dma_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $onehot0(dma_start_o));

    assert_dma_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_o |-> (dma_start_o == '0));

    assert_mask_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (mask_next_o == (($past(mask_i) == TOP) ? TOP : LVL_W'($past(mask_i) + 1'b1))));

    assert_vbl_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && vec_addr_o == VBL_ADDR) |-> ($past(mask_i) <= 3'd4));

    assert_rx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && vec_addr_o == RX_ADDR) |-> !$past(rx_disable_i));

    assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (vec_addr_o[1:0] == 2'b00 && vec_addr_o >= VBL_ADDR && vec_addr_o <= RX_ADDR));

endmodule

bind irq_accept irq_accept_chk #(
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE),
    .NUM_DMA  (NUM_DMA),
    .LVL_W    (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_i       (mask_i),
    .rx_disable_i (rx_disable_i),
    .accept_o     (accept_o),
    .mask_next_o  (mask_next_o),
    .vec_addr_o   (vec_addr_o),
    .dma_start_o  (dma_start_o)
);

// File: tb/irq_accept_test.sv
module irq_accept_test;

    typedef struct {
        logic [23:0] addr;
        logic [2:0]  mask;
        logic [3:0]  dma;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  req = '0;
    logic [7:0]  lvl_t01 = '0, lvl_t23 = '0, lvl_rx = '0;
    logic        rx_dis = 1'b0;
    logic [7:0]  chan [4];
    logic [31:0] dma_code;
    logic [2:0]  mask = '0;
    logic        accept;
    logic [2:0]  mask_next;
    logic [23:0] vec_addr;
    logic [3:0]  dma_start;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    exp_t sb [$];

    always #2.5 clk = ~clk;

    assign dma_code = {chan[3], chan[2], chan[1], chan[0]};

    irq_accept uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .lvl_t01_i    (lvl_t01),
        .lvl_t23_i    (lvl_t23),
        .lvl_rx_i     (lvl_rx),
        .rx_disable_i (rx_dis),
        .dma_code_i   (dma_code),
        .mask_i       (mask),
        .accept_o     (accept),
        .mask_next_o  (mask_next),
        .vec_addr_o   (vec_addr),
        .dma_start_o  (dma_start)
    );

    function automatic int vidx(int s);
        int t [6] = '{5, 7, 8, 9, 10, 12};
        return t[s];
    endfunction

    function automatic logic [7:0] tcode(int s);
        logic [7:0] t [6] = '{8'h0B, 8'h10, 8'h11, 8'h12, 8'h13, 8'h19};
        return t[s];
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // driver side: expected result for source s accepted at mask m
    task automatic expect_src(int s, logic [2:0] m, string tag);
        exp_t e;
        e.addr = 24'h6FB8 + 24'(4 * vidx(s));
        e.mask = (m == 3'd7) ? 3'd7 : m + 3'd1;
        e.dma  = '0;
        for (int c = 0; c < 4; c++) begin
            if (e.dma == '0 && chan[c] == tcode(s)) e.dma[c] = 1'b1;
        end
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic pulse(logic [5:0] bits);
        req = bits;
        @(negedge clk);
        req = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet(string tag);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d expected acceptances missing (expected 0)", tag, sb.size());
            sb.delete();
        end
    endtask

    // monitor: compare every acceptance against the scoreboard
    always @(negedge clk) begin
        if (rst_n && accept) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R1/R8: unexpected acceptance addr=%h mask=%0d dma=%b (expected none)",
                         vec_addr, mask_next, dma_start);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (vec_addr !== e.addr || mask_next !== e.mask || dma_start !== e.dma) begin
                    errors++;
                    $display("FAIL %s: addr=%h mask=%0d dma=%b expected addr=%h mask=%0d dma=%b",
                             e.tag, vec_addr, mask_next, dma_start, e.addr, e.mask, e.dma);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: run did not complete (expected completion)");
            summary();
            $finish;
        end
    end

    initial begin
        chan[0] = 8'h10; chan[1] = 8'h0B; chan[2] = 8'h10; chan[3] = 8'h19;
        lvl_t01 = 8'h31;   // timer0 level 1, timer1 level 3
        lvl_t23 = 8'h64;   // timer2 level 4, timer3 level 6
        lvl_rx  = 8'h02;   // receive level 2
        idle(3);
        // R9: outputs zero during reset
        checks++;
        if ({accept, mask_next, vec_addr, dma_start} !== '0) begin
            errors++;
            $display("FAIL R9: outputs %b %0d %h %b during reset (expected all zero)",
                     accept, mask_next, vec_addr, dma_start);
        end
        rst_n = 1'b1;
        idle(2);

        // R4 R6 R10: single vertical blank, DMA on channel 1
        mask = 3'd0;
        expect_src(0, 3'd0, "R4/R6 vblank");
        pulse(6'b000001);
        idle(2);
        // R6: timer0 code on channels 0 and 2, only channel 0 strobed
        mask = 3'd1;
        expect_src(1, 3'd1, "R6 first match");
        pulse(6'b000010);
        idle(2);
        // R6: timer1 code on no channel
        expect_src(2, 3'd1, "R6 no match");
        pulse(6'b000100);
        idle(2);
        quiet("R6 sequence");

        // R1 R2: timer0 level 1 held at mask 2, accepted when mask drops to 1
        mask = 3'd2;
        pulse(6'b000010);
        idle(4);
        quiet("R1 held pending");
        expect_src(1, 3'd1, "R1 released");
        mask = 3'd1;
        idle(3);
        quiet("R1 release");

        // R2: timer1 upper field (3): held at 4, taken at 3
        mask = 3'd4;
        pulse(6'b000100);
        idle(3);
        quiet("R2 timer1 held");
        expect_src(2, 3'd3, "R2 timer1 upper field");
        mask = 3'd3;
        idle(3);
        // R2: timer2 lower field (4) taken at 4, timer3 upper field (6) at 6
        mask = 3'd4;
        expect_src(3, 3'd4, "R2 timer2 lower field");
        pulse(6'b001000);
        idle(2);
        mask = 3'd7;
        pulse(6'b010000);
        idle(3);
        quiet("R2 timer3 held");
        expect_src(4, 3'd6, "R2 timer3 upper field");
        mask = 3'd6;
        idle(3);
        quiet("R2 fields");

        // R3: vertical blank held at mask 5, taken at 4
        mask = 3'd5;
        pulse(6'b000001);
        idle(3);
        quiet("R3 vblank held");
        expect_src(0, 3'd4, "R3 vblank at 4");
        mask = 3'd4;
        idle(3);

        // R5: saturation at 7 (timer3 level raised to 7)
        lvl_t23 = 8'h74;
        mask = 3'd7;
        expect_src(4, 3'd7, "R5 saturate");
        pulse(6'b010000);
        idle(3);
        quiet("R5");

        // R7: receive request dropped while disabled
        mask = 3'd0;
        rx_dis = 1'b1;
        pulse(6'b100000);
        idle(2);
        rx_dis = 1'b0;
        idle(4);
        quiet("R7 dropped");
        expect_src(5, 3'd0, "R7 enabled receive");
        pulse(6'b100000);
        idle(3);
        quiet("R7");

        // R8: all six at once, accepted in index order one per cycle
        chan[1] = 8'h12; chan[2] = 8'h12;
        for (int s = 0; s < 6; s++) expect_src(s, 3'd0, "R8 order");
        pulse(6'b111111);
        idle(8);
        quiet("R8 burst");

        // R9: pending flag cleared by reset
        mask = 3'd7;
        pulse(6'b000010);
        idle(2);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        mask = 3'd0;
        idle(4);
        quiet("R9 pending cleared");

        summary();
        $finish;
    end

endmodule